// File: doc/BRIEF.md
# Dual Burst-Buffer Flash Read Interface

This block sits between a bus master and a flash array built from 16-bit words. It handles read traffic only. Two independent line buffers each hold one aligned 32-byte line of 16 words. The two lines need not be neighbours in the address space. A read request names a byte address. If that line is held in a valid buffer, the words stream out of the buffer. If not, the least-recently-used buffer is reloaded from a simple synchronous array-read port. The reload begins at the requested word and wraps around within the line. Each word is forwarded to the bus in the cycle it arrives.

A burst runs from the requested word up to the last word of the line, one beat per clock after the first. The master can end it earlier with a stop strobe. A programmable count of extra wait cycles delays the first beat. The block also does three smaller jobs. While an erase sequence is armed, it tags every array read as a margin read. It drops both buffers on any array write or during low-power disable. It forms the enable for array block 0 from one of two sources.

Top module: `flash_burst_reader`

## Requirements
- R1: With W = `wait_cfg`, a request accepted at clock edge n whose line is held in a valid buffer gives its first beat in the cycle after edge n+1+W. That beat carries the addressed word. No array read occurs for it.
- R2: After the first beat, beats follow on consecutive clocks with word offsets rising by one. `beat_last` is high exactly on the beat at offset 15, and no beat follows it.
- R3: When `rd_stop` is high at an edge, no beat appears in the following cycle. The burst then delivers nothing more.
- R4: A request that misses starts a refill in the cycle after the accepting edge n. `arr_re` stays high for 16 consecutive cycles. `arr_addr` (a word address: line tag above a 4-bit word offset) starts at the requested word and steps up by one, wrapping within the line. The first beat appears after edge n + max(2, 1+W) and carries the array data.
- R5: Both buffers keep their lines. A miss replaces the buffer that was used less recently. After lines A, B and then A again, a miss on line C evicts B while A still hits.
- R6: An array write (`wr_req`) or `lp_dis` makes both buffers invalid. This holds even when it happens during a refill, so the next access to any line misses.
- R7: A request accepted while `lp_dis` is high raises `rd_err` for one cycle after the accepting edge. It produces no beat and no array read.
- R8: `arr_margin` is high only together with `arr_re`. It is high exactly when the margin state is armed. The state arms on an `wr_req` edge while `erase_seq` is high. It disarms on any edge where `erase_seq` is low.
- R9: `blk0_en` equals `blk0_pin` when `blk0_sel` is 0, and equals the inverse of `protect_bit` when `blk0_sel` is 1.
- R10: `rd_ready` is low while a burst or a refill is in progress. A request presented while it is low is ignored.
- R11: After reset, `rd_ready` is high. `beat_valid`, `rd_err`, `arr_re` and `arr_margin` are low, and both buffers are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, taken when `rd_ready` is high |
| rd_addr | input | ADDR_W | Byte address of the first word |
| rd_stop | input | 1 | Master ends the current burst |
| wait_cfg | input | WAIT_W | Extra wait cycles before the first beat |
| rd_ready | output | 1 | Block can accept a request |
| rd_err | output | 1 | Error response (low-power disable) |
| beat_valid | output | 1 | Data beat present |
| beat_data | output | WORD_W | Beat data |
| beat_last | output | 1 | Beat is the last word of the line |
| wr_req | input | 1 | An array write is taking place |
| lp_dis | input | 1 | Low-power disable |
| erase_seq | input | 1 | Erase sequence bit |
| arr_re | output | 1 | Array read strobe |
| arr_addr | output | ADDR_W-1 | Array word address |
| arr_margin | output | 1 | Current array read is a margin read |
| arr_rdata | input | WORD_W | Array data, valid the cycle after `arr_re` |
| blk0_sel | input | 1 | Block-0 enable source select |
| blk0_pin | input | 1 | External block-0 enable |
| protect_bit | input | 1 | Protect control bit |
| blk0_en | output | 1 | Block-0 enable |

## Verification
Several rules are checked on every cycle, whatever the traffic:
- Once a burst is streaming, it does not pause until the last word or a stop.
- Nothing follows a stop or the last word.
- Margin tagging stays inside read strobes and drops once the erase bit clears.
- An error response is never paired with array activity.
- A refill runs for more than one cycle.

Other behaviour needs the bench's reference model of tags and recency, driven through its scenarios:
- Hit and miss choice, and which buffer is evicted.
- First-beat latency against wait count and hit or miss.
- Wrapped refill addresses and delivered data.
- Invalidation by writes, including a write in the middle of a refill.
- Requests being ignored while busy.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int NUM_BUFS = 2;

  typedef enum logic {
    BS_IDLE = 1'b0,
    BS_RUN  = 1'b1
  } burst_state_t;
endpackage

// File: rtl/fbr_lookup.sv
module fbr_lookup
  import fbr_pkg::*;
#(
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             alloc,
  input  logic             alloc_buf,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             fill_ok,
  input  logic             fill_buf,
  input  logic             inval,
  input  logic             touch,
  input  logic             touch_buf,
  output logic             hit,
  output logic             hit_buf,
  output logic             victim
);
  logic [NUM_BUFS-1:0] hit_vec;
  logic                lru_q, lru_d;

  for (genvar e = 0; e < NUM_BUFS; e++) begin : g_ent
    logic             v_q, v_d, tag_en;
    logic [TAG_W-1:0] t_q;

    assign tag_en = alloc && (alloc_buf == 1'(e));

    always_comb begin
      v_d = v_q;
      if (tag_en) v_d = 1'b0;
      if (fill_ok && (fill_buf == 1'(e))) v_d = 1'b1;
      if (inval) v_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else begin
        v_q <= v_d;
        if (tag_en) t_q <= alloc_tag;
      end
    end

    assign hit_vec[e] = v_q && (t_q == look_tag);
  end

  assign hit     = |hit_vec;
  assign hit_buf = hit_vec[1];
  assign victim  = lru_q;

  // the buffer just used becomes the most recent one
  always_comb lru_d = touch ? ~touch_buf : lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= 1'b0;
    else        lru_q <= lru_d;
  end
endmodule

// File: rtl/fbr_fill.sv
module fbr_fill
  import fbr_pkg::*;
#(
  parameter int TAG_W      = 27,
  parameter int WORD_W     = 16,
  parameter int LINE_WORDS = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic                                     start_buf,
  input  logic [TAG_W-1:0]                         start_tag,
  input  logic [$clog2(LINE_WORDS)-1:0]            start_idx,
  input  logic                                     inval,
  input  logic [WORD_W-1:0]                        arr_rdata,
  input  logic                                     rd_buf,
  input  logic [$clog2(LINE_WORDS)-1:0]            rd_idx,
  output logic                                     arr_re,
  output logic [TAG_W+$clog2(LINE_WORDS)-1:0]      arr_addr,
  output logic                                     busy,
  output logic                                     done_ok,
  output logic                                     done_buf,
  output logic                                     rd_ok,
  output logic [WORD_W-1:0]                        rd_data
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam logic [OFF_W:0] CNT_FULL = (OFF_W+1)'(LINE_WORDS);

  logic [WORD_W-1:0]     store_q [NUM_BUFS][LINE_WORDS];
  logic                  busy_q, busy_d, buf_q, spoil_q, spoil_d;
  logic [TAG_W-1:0]      tag_q;
  logic [OFF_W-1:0]      issue_idx_q, issue_idx_d, pend_idx_q;
  logic [OFF_W:0]        issue_cnt_q, issue_cnt_d;
  logic                  pend_q;
  logic [LINE_WORDS-1:0] have_q, have_d;
  logic                  done, own, bypass;

  assign arr_re   = busy_q && (issue_cnt_q != CNT_FULL);
  assign arr_addr = {tag_q, issue_idx_q};
  assign busy     = busy_q;
  assign done     = busy_q && (issue_cnt_q == CNT_FULL) && pend_q;
  assign done_ok  = done && !spoil_q && !inval;
  assign done_buf = buf_q;

  always_comb begin
    busy_d      = busy_q;
    issue_idx_d = issue_idx_q;
    issue_cnt_d = issue_cnt_q;
    have_d      = have_q;
    spoil_d     = spoil_q | inval;
    if (start) begin
      busy_d      = 1'b1;
      issue_idx_d = start_idx;
      issue_cnt_d = '0;
      have_d      = '0;
      spoil_d     = inval;
    end else begin
      if (done) busy_d = 1'b0;
      if (arr_re) begin
        issue_idx_d = issue_idx_q + OFF_W'(1);
        issue_cnt_d = issue_cnt_q + (OFF_W+1)'(1);
      end
      if (pend_q) have_d[pend_idx_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      buf_q       <= 1'b0;
      tag_q       <= '0;
      issue_idx_q <= '0;
      issue_cnt_q <= '0;
      pend_q      <= 1'b0;
      pend_idx_q  <= '0;
      have_q      <= '0;
      spoil_q     <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      issue_idx_q <= issue_idx_d;
      issue_cnt_q <= issue_cnt_d;
      pend_q      <= arr_re;
      pend_idx_q  <= issue_idx_q;
      have_q      <= have_d;
      spoil_q     <= spoil_d;
      if (start) begin
        buf_q <= start_buf;
        tag_q <= start_tag;
      end
    end
  end

  // line storage: plain data registers, written with an enable
  always_ff @(posedge clk) begin
    if (pend_q) store_q[buf_q][pend_idx_q] <= arr_rdata;
  end

  // a word of the line under refill is ready once stored or arriving now
  assign own     = busy_q && (rd_buf == buf_q);
  assign bypass  = pend_q && (pend_idx_q == rd_idx);
  assign rd_ok   = !own || have_q[rd_idx] || bypass;
  assign rd_data = (own && bypass) ? arr_rdata : store_q[rd_buf][rd_idx];
endmodule

// File: rtl/fbr_burst.sv
module fbr_burst
  import fbr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 4,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              lp,
  input  logic              stop,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic [OFF_W-1:0]  start_idx,
  input  logic              sel_buf,
  input  logic              fill_busy,
  input  logic              rd_ok,
  input  logic [WORD_W-1:0] rd_data,
  output logic              ready,
  output logic              accept,
  output logic              err,
  output logic              beat_valid,
  output logic [WORD_W-1:0] beat_data,
  output logic              beat_last,
  output logic              rd_buf,
  output logic [OFF_W-1:0]  rd_idx
);
  burst_state_t      state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [OFF_W-1:0]  idx_q, idx_d;
  logic              buf_q, buf_d;
  logic              bv_q, bv_d, bl_q, bl_d, err_q, err_d;
  logic [WORD_W-1:0] bd_q, bd_d;

  assign ready  = (state_q == BS_IDLE) && !fill_busy;
  assign accept = req && ready && !lp;
  assign rd_buf = buf_q;
  assign rd_idx = idx_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    buf_d   = buf_q;
    bv_d    = 1'b0;
    bl_d    = 1'b0;
    bd_d    = bd_q;
    err_d   = 1'b0;
    case (state_q)
      BS_IDLE: begin
        if (req && ready) begin
          if (lp) begin
            err_d = 1'b1;
          end else begin
            state_d = BS_RUN;
            cnt_d   = wait_cfg;
            idx_d   = start_idx;
            buf_d   = sel_buf;
          end
        end
      end
      BS_RUN: begin
        if (stop) begin
          state_d = BS_IDLE;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - WAIT_W'(1);
        end else if (rd_ok) begin
          bv_d = 1'b1;
          bd_d = rd_data;
          bl_d = (idx_q == '1);
          if (idx_q == '1) state_d = BS_IDLE;
          else             idx_d   = idx_q + OFF_W'(1);
        end
      end
      default: state_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      buf_q   <= 1'b0;
      bv_q    <= 1'b0;
      bl_q    <= 1'b0;
      bd_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      buf_q   <= buf_d;
      bv_q    <= bv_d;
      bl_q    <= bl_d;
      bd_q    <= bd_d;
      err_q   <= err_d;
    end
  end

  assign beat_valid = bv_q;
  assign beat_data  = bd_q;
  assign beat_last  = bl_q;
  assign err        = err_q;
endmodule

// File: rtl/flash_burst_reader.sv
module flash_burst_reader
  import fbr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 16,
  parameter int LINE_WORDS = 16,
  parameter int WAIT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_stop,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              rd_ready,
  output logic              rd_err,
  output logic              beat_valid,
  output logic [WORD_W-1:0] beat_data,
  output logic              beat_last,
  input  logic              wr_req,
  input  logic              lp_dis,
  input  logic              erase_seq,
  output logic              arr_re,
  output logic [ADDR_W-2:0] arr_addr,
  output logic              arr_margin,
  input  logic [WORD_W-1:0] arr_rdata,
  input  logic              blk0_sel,
  input  logic              blk0_pin,
  input  logic              protect_bit,
  output logic              blk0_en
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int TAG_W = ADDR_W - OFF_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [TAG_W-1:0]  look_tag;
  logic [OFF_W-1:0]  start_idx, rd_idx;
  logic              addr_lsb_unused;
  logic              hit, hit_buf, victim, sel_buf, accept, start_fill;
  logic              fill_busy, done_ok, done_buf, rd_ok, rd_buf;
  logic [WORD_W-1:0] rd_data;
  logic              inval, armed_q, armed_d;

  assign look_tag        = rd_addr[ADDR_W-1:OFF_W+1];
  assign start_idx       = rd_addr[OFF_W:1];
  assign addr_lsb_unused = rd_addr[0];
  assign inval           = wr_req | lp_dis;
  assign sel_buf         = hit ? hit_buf : victim;
  assign start_fill      = accept && !hit;

  fbr_lookup #(.TAG_W(TAG_W)) u_lookup (
    .clk(clk), .rst_n(rst_int_n), .look_tag(look_tag),
    .alloc(start_fill), .alloc_buf(sel_buf), .alloc_tag(look_tag),
    .fill_ok(done_ok), .fill_buf(done_buf), .inval(inval),
    .touch(accept), .touch_buf(sel_buf),
    .hit(hit), .hit_buf(hit_buf), .victim(victim)
  );

  fbr_fill #(.TAG_W(TAG_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_fill (
    .clk(clk), .rst_n(rst_int_n), .start(start_fill), .start_buf(sel_buf),
    .start_tag(look_tag), .start_idx(start_idx), .inval(inval),
    .arr_rdata(arr_rdata), .rd_buf(rd_buf), .rd_idx(rd_idx),
    .arr_re(arr_re), .arr_addr(arr_addr), .busy(fill_busy),
    .done_ok(done_ok), .done_buf(done_buf), .rd_ok(rd_ok), .rd_data(rd_data)
  );

  fbr_burst #(.WORD_W(WORD_W), .OFF_W(OFF_W), .WAIT_W(WAIT_W)) u_burst (
    .clk(clk), .rst_n(rst_int_n), .req(rd_req), .lp(lp_dis), .stop(rd_stop),
    .wait_cfg(wait_cfg), .start_idx(start_idx), .sel_buf(sel_buf),
    .fill_busy(fill_busy), .rd_ok(rd_ok), .rd_data(rd_data),
    .ready(rd_ready), .accept(accept), .err(rd_err),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_last(beat_last),
    .rd_buf(rd_buf), .rd_idx(rd_idx)
  );

  // margin state: armed by a write during an erase sequence
  always_comb armed_d = erase_seq ? (armed_q | wr_req) : 1'b0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed_q <= 1'b0;
    else            armed_q <= armed_d;
  end

  assign arr_margin = arr_re && armed_q;
  assign blk0_en    = blk0_sel ? ~protect_bit : blk0_pin;
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_stop,
  input logic rd_err,
  input logic beat_valid,
  input logic beat_last,
  input logic arr_re,
  input logic arr_margin,
  input logic erase_seq
);
  AST_BEAT_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !rd_stop) |=> beat_valid); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_valid); // R2
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stop |=> !beat_valid); // R3
  AST_REFILL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_re) |=> arr_re); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (!arr_re && !beat_valid)); // R7
  AST_MARGIN_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    arr_margin |-> arr_re); // R8
  AST_MARGIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_seq |=> !arr_margin); // R8
endmodule

bind flash_burst_reader fbr_checker u_fbr_checker (
  .clk(clk), .rst_n(rst_n), .rd_stop(rd_stop), .rd_err(rd_err),
  .beat_valid(beat_valid), .beat_last(beat_last), .arr_re(arr_re),
  .arr_margin(arr_margin), .erase_seq(erase_seq)
);

// File: tb/flash_burst_reader_test.sv
`timescale 1ns/1ps
module flash_burst_reader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req, rd_stop, wr_req, lp_dis, erase_seq;
  logic [31:0] rd_addr;
  logic [1:0]  wait_cfg;
  logic        rd_ready, rd_err, beat_valid, beat_last;
  logic [15:0] beat_data, arr_rdata;
  logic        arr_re, arr_margin;
  logic [30:0] arr_addr;
  logic        blk0_sel, blk0_pin, protect_bit, blk0_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [26:0] mtag [2];
  logic        mval [2];
  logic        mlru;
  logic        armed;

  always #2.5 clk = ~clk;

  flash_burst_reader uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_stop(rd_stop), .wait_cfg(wait_cfg), .rd_ready(rd_ready),
    .rd_err(rd_err), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_last(beat_last), .wr_req(wr_req), .lp_dis(lp_dis),
    .erase_seq(erase_seq), .arr_re(arr_re), .arr_addr(arr_addr),
    .arr_margin(arr_margin), .arr_rdata(arr_rdata), .blk0_sel(blk0_sel),
    .blk0_pin(blk0_pin), .protect_bit(protect_bit), .blk0_en(blk0_en)
  );

  function automatic logic [15:0] mw(input logic [30:0] a);
    return (a[15:0] * 16'd41) ^ {a[30:16], 1'b1};
  endfunction

  // array model: data the cycle after the read strobe
  always @(posedge clk) if (arr_re) arr_rdata <= mw(arr_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic model_inval();
    mval[0] = 1'b0;
    mval[1] = 1'b0;
  endtask

  task automatic do_write();
    wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    if (erase_seq) armed = 1'b1;
    model_inval();
  endtask

  task automatic burst(input logic [26:0] tag, input int s, input int w,
                       input int stopn, input int wr_at);
    bit hit;
    int hb, exp_first, exp_beats, got, arrn;
    logic [3:0] wi;
    hit = 0; hb = 0;
    for (int b = 0; b < 2; b++)
      if (mval[b] && mtag[b] == tag) begin hit = 1; hb = b; end
    while (!rd_ready) @(negedge clk);
    rd_addr  = {tag, 4'(s), 1'b0};
    wait_cfg = 2'(w);
    rd_req   = 1'b1;
    @(negedge clk);
    exp_first = hit ? 1 + w : ((1 + w > 2) ? 1 + w : 2);
    exp_beats = 16 - s;
    if (stopn > 0 && stopn < exp_beats) exp_beats = stopn;
    got = 0; arrn = 0;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      rd_stop = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
      if (k == 0) begin
        chk(rd_ready == 1'b0, "R10", "ready during burst", rd_ready, 0);
        rd_req  = 1'b1;                       // R10: must be ignored
        rd_addr = {27'h5555555, 4'd3, 1'b0};
      end
      if (wr_at > 0 && k == wr_at + 1 && erase_seq) armed = 1'b1;
      if (wr_at > 0 && k == wr_at) wr_req = 1'b1;
      if (beat_valid) begin
        wi = 4'(s + got);
        chk(k == exp_first + got, got == 0 ? (hit ? "R1" : "R4") : "R2",
            "beat cycle", k, exp_first + got);
        chk(beat_data == mw({tag, wi}), hit ? "R1" : "R4", "beat data",
            beat_data, mw({tag, wi}));
        chk(beat_last == (wi == 4'd15), "R2", "last flag", beat_last, wi == 4'd15);
        got++;
        if (stopn > 0 && got == stopn) rd_stop = 1'b1;
      end
      if (arr_re) begin
        chk(arr_addr == {tag, 4'(s + arrn)}, "R4", "refill address",
            arr_addr, {tag, 4'(s + arrn)});
        chk(arr_margin == armed, "R8", "margin tag", arr_margin, armed);
        arrn++;
      end
    end
    chk(got == exp_beats, stopn > 0 ? "R3" : "R2", "beat count", got, exp_beats);
    chk(arrn == (hit ? 0 : 16), hit ? "R1" : "R4", "array reads", arrn, hit ? 0 : 16);
    if (hit) mlru = ~hb[0];
    else begin
      mtag[mlru] = tag;
      mval[mlru] = 1'b1;
      mlru = ~mlru;
    end
    if (wr_at > 0) model_inval();
  endtask

  task automatic expect_hit(input logic [26:0] tag, input bit exp, input string req);
    bit h;
    h = 0;
    for (int b = 0; b < 2; b++) if (mval[b] && mtag[b] == tag) h = 1;
    chk(h == exp, req, "reference hit state", h, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [26:0] lines [4];
    void'($urandom(32'h00C0FFEE));
    lines[0] = 27'h0000123; lines[1] = 27'h4ABCDE0;
    lines[2] = 27'h0000124; lines[3] = 27'h7FFFFFF;
    rst_n = 1'b0; rd_req = 0; rd_stop = 0; wr_req = 0; lp_dis = 0;
    erase_seq = 0; rd_addr = '0; wait_cfg = '0; arr_rdata = '0;
    blk0_sel = 0; blk0_pin = 0; protect_bit = 0;
    model_inval(); mlru = 1'b0; armed = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(rd_ready == 1'b1, "R11", "ready after reset", rd_ready, 1);
    chk(beat_valid == 1'b0, "R11", "beat after reset", beat_valid, 0);
    chk(rd_err == 1'b0, "R11", "err after reset", rd_err, 0);
    chk(arr_re == 1'b0 && arr_margin == 1'b0, "R11", "array idle", arr_re, 0);

    // R9 block-0 enable source
    for (int c = 0; c < 8; c++) begin
      blk0_sel = c[2]; blk0_pin = c[1]; protect_bit = c[0];
      #1;
      chk(blk0_en == (c[2] ? ~c[0] : c[1]), "R9", "block0 enable",
          blk0_en, c[2] ? ~c[0] : c[1]);
    end
    @(negedge clk);

    // R4 first miss (both buffers invalid after reset, R11), full line
    burst(lines[0], 0, 0, 0, 0);
    // R1 hits at several offsets and wait counts
    burst(lines[0], 5, 0, 0, 0);
    burst(lines[0], 15, 2, 0, 0);
    // R4 miss with waits and wrapped refill
    burst(lines[1], 7, 3, 0, 0);
    burst(lines[1], 9, 1, 0, 0);
    // R5 recency: A,B used; touch A; C evicts B
    burst(lines[0], 1, 0, 0, 0);
    burst(lines[2], 4, 0, 0, 0);
    expect_hit(lines[1], 0, "R5");
    burst(lines[0], 3, 1, 0, 0);
    burst(lines[1], 0, 0, 0, 0);
    // R3 master stop
    burst(lines[0], 2, 0, 3, 0);
    burst(lines[1], 6, 2, 1, 0);
    // R6 write drops both buffers
    do_write();
    @(negedge clk);
    burst(lines[0], 0, 0, 0, 0);
    // R7 low-power request
    lp_dis = 1'b1; rd_addr = {lines[0], 4'd0, 1'b0}; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_err == 1'b1, "R7", "error response", rd_err, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!beat_valid && !arr_re && !rd_err, "R7", "quiet after error",
          {beat_valid, arr_re, rd_err}, 0);
    end
    lp_dis = 1'b0;
    model_inval();
    @(negedge clk);
    burst(lines[0], 8, 0, 0, 0);   // R6: missed after low-power
    // R6 write in the middle of a refill
    burst(lines[3], 2, 0, 0, 3);
    burst(lines[3], 2, 0, 0, 0);
    // R8 margin tagging
    erase_seq = 1'b1;
    @(negedge clk);
    burst(lines[2], 0, 0, 0, 0);    // not armed yet
    do_write();
    @(negedge clk);
    burst(lines[1], 4, 0, 0, 0);    // armed
    erase_seq = 1'b0;
    @(negedge clk);
    armed = 1'b0;
    burst(lines[2], 0, 0, 0, 0);    // disarmed

    // constrained random traffic
    for (int i = 0; i < 60; i++) begin
      int li, s, w, st;
      li = int'($urandom_range(0, 3));
      s  = int'($urandom_range(0, 15));
      w  = int'($urandom_range(0, 3));
      st = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 6)) : 0;
      burst(lines[li], s, w, st, 0);
    end

    done = 1;
    report();
    $finish;
  end
endmodule